// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block links two parallel data buses, side A and side B. Each direction of transfer has its own storage register, its own capture strobe, its own choice between live and stored data, and its own output enable. Live data lets one bus follow the other with a single register stage. Stored data lets a word captured earlier be presented while the source bus carries other traffic.

Each bus appears as an input word, an output word and a drive flag, so the block contains no bidirectional nets. The integrator resolves each bus outside the block. If both directions are enabled and both pass live data, each bus feeds the other through one register. When every other driver lets go, that loop keeps both buses at their last value.

The outputs are registered on the system clock. A change of select or enable can only take effect at a clock edge, so the driven words never glitch when the source changes. The capture strobes are sampled on the system clock, and each storage register loads on the rising edge of its own strobe.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage registers, both output words and both drive flags become zero.
- R2: The A-to-B storage register loads `a_in` at a clock edge where `cap_ab` is high and was low at the previous edge. This happens whatever the selects and enables are. Holding `cap_ab` high does not load it again.
- R3: The B-to-A storage register loads `b_in` at a clock edge where `cap_ba` is high and was low at the previous edge. This happens whatever the selects and enables are. Holding `cap_ba` high does not load it again.
- R4: At an edge where `drv_b_en` is 1 and `sel_ab` is 0, `b_drv` becomes 1 and `b_out` becomes the `a_in` sampled at that edge.
- R5: At an edge where `drv_b_en` is 1 and `sel_ab` is 1, `b_out` becomes the A-to-B stored value held before that edge. A capture at the same edge shows on `b_out` one cycle later.
- R6: The A side uses `drv_a_n` (active low) and `sel_ba`. With `drv_a_n` 0, `a_drv` becomes 1. `a_out` becomes the `b_in` sampled at that edge when `sel_ba` is 0, or the B-to-A stored value held before the edge when `sel_ba` is 1.
- R7: At an edge where a side's enable is inactive (`drv_b_en` 0, or `drv_a_n` 1), that side's output word becomes zero and its drive flag becomes 0.
- R8: With both selects 0 and both sides enabled, once the external drivers release both buses, each resolved bus keeps its last value on every following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Resolved value of bus A |
| a_out | output | WIDTH | Word the block drives onto bus A |
| a_drv | output | 1 | Block drives bus A when 1 |
| b_in | input | WIDTH | Resolved value of bus B |
| b_out | output | WIDTH | Word the block drives onto bus B |
| b_drv | output | 1 | Block drives bus B when 1 |
| cap_ab | input | 1 | Capture strobe for the A-to-B register, loads on its rise |
| cap_ba | input | 1 | Capture strobe for the B-to-A register, loads on its rise |
| sel_ab | input | 1 | 0: live A to B, 1: stored A to B |
| sel_ba | input | 1 | 0: live B to A, 1: stored B to A |
| drv_b_en | input | 1 | Enables the B-side drivers, active high |
| drv_a_n | input | 1 | Enables the A-side drivers, active low |

## Verification
A capture and a stored-data transfer can happen at the same edge in one direction. In that case the output must show the previous stored word, and the new word must appear one cycle later. The sweep covers every mix of selects and enables and toggles the strobes on derived bit patterns, so this case occurs many times. Each result is compared against a reference built in the bench from the requirements. Separate sequences cover a strobe held high, and the hold loop after both external drivers have released their buses.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/dbx_strobe_edge.sv
module dbx_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/dbx_lane.sv
module dbx_lane #(
  parameter int WIDTH         = 8,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src,
  input  logic             cap_strobe,
  input  logic             sel_stored,
  input  logic             oe_pin,
  output logic [WIDTH-1:0] dst_dat,
  output logic             dst_oe
);
  import dbx_pkg::*;

  logic             cap_rise;
  logic             oe_on;
  logic [WIDTH-1:0] stor_q;
  src_sel_e         src_sel;

  dbx_strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_strobe),
    .rise   (cap_rise)
  );

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign oe_on = ~oe_pin;
    end else begin : g_oe_high
      assign oe_on = oe_pin;
    end
  endgenerate

  assign src_sel = sel_stored ? SRC_STORED : SRC_LIVE;

  // Storage register: loads on a strobe rise regardless of select or enable.
  always_ff @(posedge clk) begin
    if (rst)           stor_q <= '0;
    else if (cap_rise) stor_q <= src;
  end

  // Registered output stage: select changes cannot glitch the driven word.
  always_ff @(posedge clk) begin
    if (rst) begin
      dst_dat <= '0;
      dst_oe  <= 1'b0;
    end else begin
      dst_oe <= oe_on;
      if (!oe_on)                    dst_dat <= '0;
      else if (src_sel == SRC_STORED) dst_dat <= stor_q;
      else                           dst_dat <= src;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (dst_dat == '0 && !dst_oe && stor_q == '0));

  p_capture_only_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(stor_q) |-> $past(cap_rise));

  p_live_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (oe_on && !sel_stored) |=> (dst_oe && dst_dat == $past(src)));

  p_stored_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (oe_on && sel_stored) |=> (dst_oe && dst_dat == $past(stor_q)));

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !dst_oe |-> dst_dat == '0);
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             drv_b_en,
  input  logic             drv_a_n
);
  // A-to-B direction: drives bus B, enable active high.
  dbx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_ab (
    .clk        (clk),
    .rst        (rst),
    .src        (a_in),
    .cap_strobe (cap_ab),
    .sel_stored (sel_ab),
    .oe_pin     (drv_b_en),
    .dst_dat    (b_out),
    .dst_oe     (b_drv)
  );

  // B-to-A direction (R3, R6): drives bus A, enable active low.
  dbx_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_ba (
    .clk        (clk),
    .rst        (rst),
    .src        (b_in),
    .cap_strobe (cap_ba),
    .sel_stored (sel_ba),
    .oe_pin     (drv_a_n),
    .dst_dat    (a_out),
    .dst_oe     (a_drv)
  );

  // R8: both live and enabled closes a one-register loop between the buses.
  p_loop_r8: assert property (@(posedge clk) disable iff (rst)
    (drv_b_en && !drv_a_n && !sel_ab && !sel_ba) |=>
      (a_drv && b_drv && a_out == $past(b_in) && b_out == $past(a_in)));
endmodule

// File: tb/sim_dual_bus_xcvr.sv
module sim_dual_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic ext_a_en = 1'b1, ext_b_en = 1'b1;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0;
  logic drv_b_en = 0, drv_a_n = 1;
  logic [W-1:0] a_out, b_out, a_bus, b_bus;
  logic a_drv, b_drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bus resolution: external driver wins, then the block; a floating bus reads 0.
  assign a_bus = ext_a_en ? ext_a : (a_drv ? a_out : '0);
  assign b_bus = ext_b_en ? ext_b : (b_drv ? b_out : '0);

  always #2 clk = ~clk;

  dual_bus_xcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst),
    .a_in(a_bus), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_bus), .b_out(b_out), .b_drv(b_drv),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .drv_b_en(drv_b_en), .drv_a_n(drv_a_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [W-1:0] m_ab, m_ba, e_b, e_a;
    logic p_ab, p_ba;
    m_ab = '0; m_ba = '0; p_ab = 0; p_ba = 0;

    // R1: reset state
    tick(); tick();
    check("R1 b_out", {b_drv, b_out}, '0);
    check("R1 a_out", {a_drv, a_out}, '0);
    rst = 0;

    // R1: stored values are zero after reset
    sel_ab = 1; sel_ba = 1; drv_b_en = 1; drv_a_n = 0;
    ext_a = 8'hFF; ext_b = 8'hEE;
    tick();
    check("R1 stored ab", {b_drv, b_out}, {1'b1, 8'h00});
    check("R1 stored ba", {a_drv, a_out}, {1'b1, 8'h00});

    // Sweep of every select/enable mix with varied strobes and data (R2..R7)
    for (int i = 0; i < 256; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      sel_ab = iv[0]; sel_ba = iv[1]; drv_b_en = iv[2]; drv_a_n = iv[3];
      cap_ab = iv[4]; cap_ba = iv[5] ^ iv[4] ^ iv[6];
      ext_a = 8'(i * 29 + 3); ext_b = 8'(i * 113 + 71);
      e_b = drv_b_en ? (sel_ab ? m_ab : ext_a) : '0;
      e_a = !drv_a_n ? (sel_ba ? m_ba : ext_b) : '0;
      tick();
      if (!drv_b_en)  check("R7 b side", {b_drv, b_out}, {1'b0, e_b});
      else if (sel_ab) check("R5 b stored", {b_drv, b_out}, {1'b1, e_b});
      else            check("R4 b live", {b_drv, b_out}, {1'b1, e_b});
      if (drv_a_n)    check("R7 a side", {a_drv, a_out}, {1'b0, e_a});
      else            check("R6 a side", {a_drv, a_out}, {1'b1, e_a});
      if (cap_ab && !p_ab) m_ab = ext_a;
      if (cap_ba && !p_ba) m_ba = ext_b;
      p_ab = cap_ab; p_ba = cap_ba;
    end

    // R2/R3: capture with drivers off, strobe held high, no recapture
    cap_ab = 0; cap_ba = 0; drv_b_en = 0; drv_a_n = 1; sel_ab = 0; sel_ba = 0;
    tick();
    cap_ab = 1; cap_ba = 1; ext_a = 8'h3C; ext_b = 8'hA5;
    tick();
    ext_a = 8'hC3; ext_b = 8'h5A;
    tick(); tick();
    sel_ab = 1; sel_ba = 1; drv_b_en = 1; drv_a_n = 0;
    tick();
    check("R2 held strobe", {b_drv, b_out}, {1'b1, 8'h3C});
    check("R3 held strobe", {a_drv, a_out}, {1'b1, 8'hA5});

    // R5: capture and stored select at the same edge
    cap_ab = 0; tick();
    cap_ab = 1; ext_a = 8'h77;
    tick();
    check("R5 same-edge old", {b_drv, b_out}, {1'b1, 8'h3C});
    tick();
    check("R5 same-edge new", {b_drv, b_out}, {1'b1, 8'h77});

    // R8: hold loop after external drivers release
    cap_ab = 0; cap_ba = 0; sel_ab = 0; sel_ba = 0;
    ext_a = 8'h5A; ext_b_en = 0;
    tick(); tick(); tick();
    ext_a_en = 0;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R8 hold a", {1'b0, a_bus}, {1'b0, 8'h5A});
      check("R8 hold b", {1'b0, b_bus}, {1'b0, 8'h5A});
    end

    report();
  end
endmodule